// File: doc/BRIEF.md
# Look-Ahead Zero-Wait Memory Responder

This block answers memory requests from a processor that issues one transfer at a time over a valid/ready bus. It holds a synchronous single-port RAM with byte lanes. The requester also has an early-notice port. That port pulses a read or write indication one cycle before the matching request raises valid, and it carries the coming address along with the pulse. The block starts the RAM read on that notice. The read word is then already sitting in the RAM output register when valid rises, so ready can go high in that same cycle.

A request that arrives without early notice still works, at the cost of one wait cycle. The block issues the RAM read itself and answers in the next cycle. Writes never take the zero-wait path. The byte lanes are written on the clock edge at the end of the first valid cycle, and ready follows in the second cycle. The word index is taken from the address bits just above the byte offset. All other address bits are ignored, so the RAM aliases across the address space.

Top module: `lookahead_mem_resp`

## Requirements
- R1: While reset is low, ready stays low even if valid is high. A read-ahead pulse seen during reset is discarded, so the first read after reset without a fresh pulse is answered in its second cycle.
- R2: Ready is low in every cycle in which valid is low.
- R3: A strobe value of 0 marks a read. Read data is the word stored at index `addr[IDX_W+1:2]`. The write data on a read is ignored, and the stored word stays unchanged.
- R4: A nonzero strobe marks a write. Strobe bit k selects byte lane k, which is data bits `[8k+7:8k]`. Only the selected lanes of the word change.
- R5: When the read-ahead pulse is high in the cycle before valid rises for a read, ready is high in the first valid cycle and carries the correct data.
- R6: A write gets ready in its second valid cycle, never in its first. This holds whether or not a write-ahead pulse came before it.
- R7: A read with no read-ahead pulse in the cycle before it gets ready in its second valid cycle, with correct data.
- R8: One read-ahead pulse serves only the transfer that directly follows it. A later read without its own pulse takes the one-wait path.
- R9: Address bits below bit 2 and above the index field have no effect. Two addresses with the same index reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request active; held until ready |
| req_instr | input | 1 | Instruction-fetch flag (accepted, no effect) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| req_wstrb | input | DATA_W/8 | Byte strobes; 0 means read |
| req_ready | output | 1 | Transfer complete this cycle |
| req_rdata | output | DATA_W | Read data, valid while ready is high on a read |
| la_read | input | 1 | Early pulse: a read starts next cycle |
| la_write | input | 1 | Early pulse: a write starts next cycle |
| la_addr | input | ADDR_W | Address of the coming transfer |
| la_wdata | input | DATA_W | Early copy of write data (not used) |
| la_wstrb | input | DATA_W/8 | Early copy of strobes (not used) |

## Verification
Reads are run three ways: right after a read-ahead pulse, with no pulse at all, and as a second read after a pulse that an earlier read already used. The ready cycle tells the zero-wait path apart from the fallback path, and the third case shows that one pulse serves only one transfer. Writes are run with and without a write-ahead pulse and with sparse strobe patterns, then read back, which shows both the one-wait timing and that only the selected lanes change. Reads that carry junk write data, accesses to aliased addresses, and a reset that arrives during a read-ahead pulse cover the cases where an input must have no effect.

// File: rtl/lamr_pkg.sv
package lamr_pkg;
   typedef enum logic [1:0] {
      RAM_IDLE  = 2'd0,
      RAM_READ  = 2'd1,
      RAM_WRITE = 2'd2
   } ram_op_e;
endpackage

// File: rtl/lamr_sram.sv
module lamr_sram
   import lamr_pkg::*;
#(
   parameter int LANES = 4,
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic               clk,
   input  ram_op_e            op,
   input  logic [IDX_W-1:0]   idx,
   input  logic [LANES*8-1:0] wdata,
   input  logic [LANES-1:0]   wstrb,
   output logic [LANES*8-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] cells [DEPTH];
      logic [7:0] dout_q;

      always_ff @(posedge clk) begin
         if (op == RAM_WRITE && wstrb[g])
            cells[idx] <= wdata[g*8 +: 8];
         if (op == RAM_READ)
            dout_q <= cells[idx];
      end

      assign rdata[g*8 +: 8] = dout_q;
   end
endmodule

// File: rtl/lamr_ctrl.sv
module lamr_ctrl
   import lamr_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LANES-1:0] req_wstrb,
   input  logic [IDX_W-1:0] req_idx,
   input  logic             la_read,
   input  logic             la_write,
   input  logic [IDX_W-1:0] la_idx,
   output logic             req_ready,
   output ram_op_e          ram_op,
   output logic [IDX_W-1:0] ram_idx
);
   logic prefetch_q;
   logic second_q;
   logic is_write;
   logic fast_hit;
   logic need_service;

   assign is_write     = |req_wstrb;
   assign fast_hit     = prefetch_q & ~is_write;
   assign req_ready    = rst_n & req_valid & (fast_hit | second_q);
   assign need_service = rst_n & req_valid & ~second_q & ~fast_hit;

   always_comb begin
      ram_op  = RAM_IDLE;
      ram_idx = req_idx;
      if (need_service && is_write) begin
         ram_op = RAM_WRITE;
      end else if (la_read) begin
         ram_op  = RAM_READ;
         ram_idx = la_idx;
      end else if (need_service) begin
         ram_op = RAM_READ;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prefetch_q <= 1'b0;
         second_q   <= 1'b0;
      end else begin
         second_q <= need_service;
         if (la_read)
            prefetch_q <= 1'b1;
         else if (la_write || (req_valid && req_ready))
            prefetch_q <= 1'b0;
      end
   end

   assert_zero_wait_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(la_read && rst_n) && req_valid && !(|req_wstrb)) |-> req_ready);

   assert_write_not_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_valid) && (|req_wstrb)) |-> !req_ready);

   assert_write_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (|req_wstrb) && !req_ready) |=> (req_ready || !req_valid));

   assert_one_wait_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_ready || !req_valid));

   assert_no_port_clash_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(la_read && need_service && is_write));
endmodule

// File: rtl/lookahead_mem_resp.sv
module lookahead_mem_resp
   import lamr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_instr,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_wstrb,
   output logic                req_ready,
   output logic [DATA_W-1:0]   req_rdata,
   input  logic                la_read,
   input  logic                la_write,
   input  logic [ADDR_W-1:0]   la_addr,
   input  logic [DATA_W-1:0]   la_wdata,
   input  logic [DATA_W/8-1:0] la_wstrb
);
   localparam int LANES = DATA_W / 8;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int OFF_W = $clog2(LANES);
   localparam int TOP_W = IDX_W + OFF_W;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("DATA_W must be a multiple of 8, at least 16");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W <= TOP_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index and offset bits");
   end

   logic [IDX_W-1:0] req_idx;
   logic [IDX_W-1:0] la_idx;
   logic [IDX_W-1:0] ram_idx;
   ram_op_e          ram_op;

   assign req_idx = req_addr[OFF_W +: IDX_W];
   assign la_idx  = la_addr[OFF_W +: IDX_W];

   wire unused_inputs = ^{req_instr, la_wdata, la_wstrb,
                          req_addr[OFF_W-1:0], req_addr[ADDR_W-1:TOP_W],
                          la_addr[OFF_W-1:0], la_addr[ADDR_W-1:TOP_W]};

   lamr_ctrl #(
      .LANES(LANES),
      .IDX_W(IDX_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_wstrb(req_wstrb),
      .req_idx  (req_idx),
      .la_read  (la_read),
      .la_write (la_write),
      .la_idx   (la_idx),
      .req_ready(req_ready),
      .ram_op   (ram_op),
      .ram_idx  (ram_idx)
   );

   lamr_sram #(
      .LANES(LANES),
      .DEPTH(DEPTH)
   ) u_sram (
      .clk  (clk),
      .op   (ram_op),
      .idx  (ram_idx),
      .wdata(req_wdata),
      .wstrb(req_wstrb),
      .rdata(req_rdata)
   );

   assert_write_has_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_op == RAM_WRITE) |-> (|req_wstrb));

   assert_read_holds_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ram_op != RAM_READ && rst_n)) |-> $stable(req_rdata));
endmodule

// File: tb/sim_lookahead_mem_resp.sv
module sim_lookahead_mem_resp;
   localparam int DEPTH = 256;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_instr, req_ready;
   logic [31:0] req_addr, req_wdata, req_rdata;
   logic [3:0]  req_wstrb;
   logic        la_read, la_write;
   logic [31:0] la_addr, la_wdata;
   logic [3:0]  la_wstrb;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [31:0] model [int];

   always #4 clk = ~clk;

   lookahead_mem_resp u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_instr(req_instr), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_wstrb(req_wstrb), .req_ready(req_ready),
      .req_rdata(req_rdata),
      .la_read(la_read), .la_write(la_write), .la_addr(la_addr),
      .la_wdata(la_wdata), .la_wstrb(la_wstrb)
   );

   function automatic int widx(logic [31:0] a);
      return int'(a[31:2]) & (DEPTH - 1);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one transfer with an optional early pulse; expected ready cycle from the requirements
   task automatic xfer(bit la, bit wr, logic [31:0] a, logic [31:0] d,
                       logic [3:0] s, string req);
      logic [3:0]  strb;
      logic [31:0] old;
      bit          fast;
      strb = wr ? s : 4'h0;
      fast = la && !wr;
      @(negedge clk);
      la_read  = la && !wr;
      la_write = la && wr;
      la_addr  = a;
      la_wdata = d;
      la_wstrb = strb;
      @(negedge clk);
      la_read   = 1'b0;
      la_write  = 1'b0;
      req_valid = 1'b1;
      req_addr  = a;
      req_wdata = d;
      req_wstrb = strb;
      req_instr = !wr;
      for (int c = 0; c < 3; c++) begin
         #3;
         check(req, {31'd0, req_ready}, {31'd0, fast ? (c == 0) : (c == 1)});
         if (req_ready) begin
            if (!wr) begin
               check(req, req_rdata, model[widx(a)]);
            end else begin
               old = model.exists(widx(a)) ? model[widx(a)] : 32'h0;
               for (int k = 0; k < 4; k++)
                  if (strb[k]) old[k*8 +: 8] = d[k*8 +: 8];
               model[widx(a)] = old;
            end
            break;
         end
         @(negedge clk);
      end
      @(negedge clk);
      req_valid = 1'b0;
      #3 check("R2", {31'd0, req_ready}, 32'd0);
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_instr = 1'b0; req_addr = '0;
      req_wdata = '0; req_wstrb = '0; la_read = 1'b0; la_write = 1'b0;
      la_addr = '0; la_wdata = '0; la_wstrb = '0;
      @(negedge clk);
      req_valid = 1'b1;
      #3 check("R1", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      #3 check("R1", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b1;

      // fill words, with and without a write-ahead pulse
      for (int i = 0; i < 8; i++)
         xfer(i[0], 1'b1, 32'(i * 4), 32'hA500_0000 + 32'(i * 32'h01010101), 4'hF, "R6");

      // zero-wait reads and one-wait reads
      for (int i = 0; i < 8; i++)
         xfer(1'b1, 1'b0, 32'(i * 4), 32'h0, 4'h0, "R5");
      for (int i = 7; i >= 0; i--)
         xfer(1'b0, 1'b0, 32'(i * 4) | 32'(i & 3), 32'h0, 4'h0, "R7");

      // partial lanes
      xfer(1'b1, 1'b1, 32'h0000_000C, 32'h1122_3344, 4'b0101, "R4");
      xfer(1'b1, 1'b0, 32'h0000_000C, 32'h0, 4'h0, "R4");
      xfer(1'b0, 1'b1, 32'h0000_0014, 32'hDEAD_BEEF, 4'b1000, "R4");
      xfer(1'b0, 1'b0, 32'h0000_0014, 32'h0, 4'h0, "R4");

      // read carrying junk write data leaves the word alone
      @(negedge clk);
      la_read = 1'b1; la_addr = 32'h8; la_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      la_read = 1'b0; req_valid = 1'b1; req_addr = 32'h8;
      req_wdata = 32'hFFFF_FFFF; req_wstrb = 4'h0;
      #3 check("R3", {31'd0, req_ready}, 32'd1);
      check("R3", req_rdata, model[2]);
      @(negedge clk);
      req_valid = 1'b0;
      xfer(1'b0, 1'b0, 32'h8, 32'h0, 4'h0, "R3");

      // aliasing on high and low address bits
      xfer(1'b1, 1'b1, 32'h0000_1410, 32'h0BAD_F00D, 4'hF, "R9");
      xfer(1'b1, 1'b0, 32'h0000_0012, 32'h0, 4'h0, "R9");
      xfer(1'b0, 1'b0, 32'hFFFF_F811, 32'h0, 4'h0, "R9");

      // one pulse serves one read only
      xfer(1'b1, 1'b0, 32'h4, 32'h0, 4'h0, "R8");
      xfer(1'b0, 1'b0, 32'h18, 32'h0, 4'h0, "R8");

      // reset during a read-ahead pulse discards it
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      la_read = 1'b1; la_addr = 32'h1C;
      @(negedge clk);
      la_read = 1'b0; rst_n = 1'b1; req_valid = 1'b1;
      req_addr = 32'h1C; req_wstrb = 4'h0;
      #3 check("R1", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      #3 check("R1", {31'd0, req_ready}, 32'd1);
      check("R1", req_rdata, model[7]);
      @(negedge clk);
      req_valid = 1'b0;
      #3 check("R2", {31'd0, req_ready}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule